// File: doc/BRIEF.md
# Multi-User Inter-Processor Mailbox

This block moves 32-bit words between processors through a set of small hardware queues. A sender writes a queue's message register to append a word, and a receiver reads the same register to take the oldest word out. Each queue has two read-only status words: one says whether the queue is full, the other gives its current fill level. The number of queues, the queue depth and the number of users are parameters.

Each user (one per processor) has its own interrupt line, backed by a pending-event register and an enable mask. Every queue produces two events that go to all users at once. The first is "a word arrived". The second is "space became available", which marks readiness to transmit, not completion of a transfer. Each user then picks the events it wants through its own mask. A build-time parameter selects how the masks are written. In one variant a single register is overwritten with the new mask. In the other, one register ORs bits into the mask and a separate register removes bits when written with ones.

Top module: `mbx_top`

## Requirements
- R1: After a synchronous reset, every queue is empty, every pending-event and enable register reads 0, and every interrupt line is low.
- R2: Offset 0x000 reads the REV_ID parameter. Any offset not listed in these requirements reads 0, and writes to it have no effect.
- R3: Writing the message register of queue m (offset 0x040+4·m) appends the word. Reading it returns and removes the oldest word, in first-in first-out order. The level register at 0x0C0+4·m returns the entry count in its low bits.
- R4: The full register at 0x080+4·m reads 1 when the queue holds DEPTH (4) words and 0 otherwise. A write to a full queue is dropped, and neither the count nor the contents change.
- R5: Reading the message register of an empty queue returns 0 and leaves the count at 0.
- R6: For queue m, bit 2·m of every user's pending register is set by each accepted write. Bit 2·m+1 is set by each read that takes the queue from full to not full.
- R7: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged. An event that arrives in the same cycle as the clear keeps the bit set.
- R8: Interrupt line u is high exactly one clock after (pending[u] AND enable[u]) becomes non-zero, and low one clock after it becomes zero.
- R9: With LAYOUT=0, user u has its pending register at 0x100+8·u and its enable register at 0x104+8·u. A write to the enable register replaces the whole mask.
- R10: With LAYOUT=1, user u has its pending register at 0x104+0x10·u. A write to 0x108+0x10·u ORs bits into the mask, and a write of ones to 0x10C+0x10·u clears those mask bits. Both of these registers read back the mask, and 0x100 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | NUM_USERS | One interrupt line per user |

## Verification
A write takes effect at the clock edge that samples it. The queue contents, the count and the pending bits all change at that edge. Read data appears on bus_rdata one edge after the read strobe, and the pop from a message read happens at that same edge. An interrupt line follows its masked pending bits one edge later still. The bench drives the bus on falling edges. A monitor flop marks each edge that sampled a read, and on the next falling edge the monitor pops the expected word from a queue and compares it. Interrupt checks are made one idle cycle after the write that changed the pending or enable state.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int MBX_DW        = 32;
  // register bases (byte offsets)
  localparam int OFS_REV       = 'h000;
  localparam int OFS_MSG       = 'h040;
  localparam int OFS_FULL      = 'h080;
  localparam int OFS_LEVEL     = 'h0C0;
  localparam int FIFO_STRIDE   = 4;
  // interrupt layout variants
  localparam int LAYOUT_RMW    = 0;
  localparam int LAYOUT_SETCLR = 1;
  localparam int L0_PEND_BASE  = 'h100;
  localparam int L0_STRIDE     = 8;
  localparam int L1_PEND_BASE  = 'h104;
  localparam int L1_STRIDE     = 'h10;
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              push_ok,
  output logic              pop_from_full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              empty, pop_ok;

  assign full          = (count == CNT_W'(DEPTH));
  assign empty         = (count == '0);
  assign push_ok       = push & ~full & ~rst;
  assign pop_ok        = pop & ~empty & ~rst;
  assign pop_from_full = pop_ok & full;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage: write port only, no reset, so it can map to RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wdata;
  end

  assign head = empty ? '0 : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= bump(wr_ptr);
      if (pop_ok)  rd_ptr <= bump(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/mbx_decode.sv
module mbx_decode import mbx_pkg::*; #(
  parameter int NUM_FIFOS = 4,
  parameter int NUM_USERS = 4,
  parameter int LAYOUT    = LAYOUT_SETCLR,
  parameter int ADDR_W    = 12
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic                 rev_hit,
  output logic [NUM_FIFOS-1:0] msg_hit,
  output logic [NUM_FIFOS-1:0] full_hit,
  output logic [NUM_FIFOS-1:0] lvl_hit,
  output logic [NUM_USERS-1:0] pend_hit,
  output logic [NUM_USERS-1:0] mask_hit,
  output logic [NUM_USERS-1:0] set_hit,
  output logic [NUM_USERS-1:0] clr_hit
);
  assign rev_hit = (addr == ADDR_W'(OFS_REV));

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
    assign msg_hit[m]  = (addr == ADDR_W'(OFS_MSG   + FIFO_STRIDE * m));
    assign full_hit[m] = (addr == ADDR_W'(OFS_FULL  + FIFO_STRIDE * m));
    assign lvl_hit[m]  = (addr == ADDR_W'(OFS_LEVEL + FIFO_STRIDE * m));
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    if (LAYOUT == LAYOUT_RMW) begin : g_rmw
      assign pend_hit[u] = (addr == ADDR_W'(L0_PEND_BASE + L0_STRIDE * u));
      assign mask_hit[u] = (addr == ADDR_W'(L0_PEND_BASE + 4 + L0_STRIDE * u));
      assign set_hit[u]  = 1'b0;
      assign clr_hit[u]  = 1'b0;
    end else begin : g_setclr
      assign pend_hit[u] = (addr == ADDR_W'(L1_PEND_BASE + L1_STRIDE * u));
      assign mask_hit[u] = 1'b0;
      assign set_hit[u]  = (addr == ADDR_W'(L1_PEND_BASE + 4 + L1_STRIDE * u));
      assign clr_hit[u]  = (addr == ADDR_W'(L1_PEND_BASE + 8 + L1_STRIDE * u));
    end
  end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int EV_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [EV_W-1:0] ev,
  input  logic            wr_pend,
  input  logic            wr_mask,
  input  logic            wr_set,
  input  logic            wr_clr,
  input  logic [EV_W-1:0] wdata,
  output logic [EV_W-1:0] pending,
  output logic [EV_W-1:0] enable,
  output logic            irq
);
  logic [EV_W-1:0] pend_nxt, en_nxt;

  always_comb begin
    pend_nxt = (pending & ~(wr_pend ? wdata : '0)) | ev;
    en_nxt   = enable;
    if (wr_mask) en_nxt = wdata;
    if (wr_set)  en_nxt = en_nxt | wdata;
    if (wr_clr)  en_nxt = en_nxt & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= '0;
      enable  <= '0;
      irq     <= 1'b0;
    end else begin
      pending <= pend_nxt;
      enable  <= en_nxt;
      irq     <= |(pending & enable);
    end
  end
endmodule

// File: rtl/mbx_top.sv
module mbx_top import mbx_pkg::*; #(
  parameter int          NUM_FIFOS = 4,
  parameter int          NUM_USERS = 4,
  parameter int          DEPTH     = 4,
  parameter int          LAYOUT    = LAYOUT_SETCLR,
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] REV_ID    = 32'h0001_0200
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_USERS-1:0] irq_out
);
  localparam int EV_W  = 2 * NUM_FIFOS;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                 rev_hit;
  logic [NUM_FIFOS-1:0] msg_hit, full_hit, lvl_hit;
  logic [NUM_USERS-1:0] pend_hit, mask_hit, set_hit, clr_hit;
  logic                 do_wr, do_rd;

  logic [NUM_FIFOS-1:0][MBX_DW-1:0] fifo_head;
  logic [NUM_FIFOS-1:0][CNT_W-1:0]  fifo_cnt;
  logic [NUM_FIFOS-1:0]             fifo_full, fifo_push_ok, fifo_pop_ff;
  logic [EV_W-1:0]                  ev;
  logic [NUM_USERS-1:0][EV_W-1:0]   pend, mask;
  logic [31:0]                      rd_mux;

  assign do_wr = bus_sel & bus_wr;
  assign do_rd = bus_sel & ~bus_wr;

  mbx_decode #(
    .NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS),
    .LAYOUT(LAYOUT), .ADDR_W(ADDR_W)
  ) u_dec (
    .addr(bus_addr), .rev_hit(rev_hit),
    .msg_hit(msg_hit), .full_hit(full_hit), .lvl_hit(lvl_hit),
    .pend_hit(pend_hit), .mask_hit(mask_hit),
    .set_hit(set_hit), .clr_hit(clr_hit)
  );

  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_q
    mbx_fifo #(.DEPTH(DEPTH), .DATA_W(MBX_DW), .CNT_W(CNT_W)) u_fifo (
      .clk(clk), .rst(rst),
      .push(do_wr & msg_hit[m]),
      .pop(do_rd & msg_hit[m]),
      .wdata(bus_wdata),
      .head(fifo_head[m]),
      .count(fifo_cnt[m]),
      .full(fifo_full[m]),
      .push_ok(fifo_push_ok[m]),
      .pop_from_full(fifo_pop_ff[m])
    );
    // interleaved event bits: arrival at 2m, space at 2m+1
    assign ev[2*m]   = fifo_push_ok[m];
    assign ev[2*m+1] = fifo_pop_ff[m];
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_usr
    mbx_user_irq #(.EV_W(EV_W)) u_irq (
      .clk(clk), .rst(rst), .ev(ev),
      .wr_pend(do_wr & pend_hit[u]),
      .wr_mask(do_wr & mask_hit[u]),
      .wr_set(do_wr & set_hit[u]),
      .wr_clr(do_wr & clr_hit[u]),
      .wdata(bus_wdata[EV_W-1:0]),
      .pending(pend[u]),
      .enable(mask[u]),
      .irq(irq_out[u])
    );
  end

  // one-hot read select
  always_comb begin
    rd_mux = '0;
    if (rev_hit) rd_mux = REV_ID;
    for (int m = 0; m < NUM_FIFOS; m++) begin
      if (msg_hit[m])  rd_mux = fifo_head[m];
      if (full_hit[m]) rd_mux = {31'b0, fifo_full[m]};
      if (lvl_hit[m]) begin
        rd_mux = '0;
        rd_mux[CNT_W-1:0] = fifo_cnt[m];
      end
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (pend_hit[u]) begin
        rd_mux = '0;
        rd_mux[EV_W-1:0] = pend[u];
      end
      if (mask_hit[u] | set_hit[u] | clr_hit[u]) begin
        rd_mux = '0;
        rd_mux[EV_W-1:0] = mask[u];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (do_rd) bus_rdata <= rd_mux;
    else            bus_rdata <= '0;
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int NUM_FIFOS = 4,
  parameter int NUM_USERS = 4,
  parameter int DEPTH     = 4,
  parameter int CNT_W     = 3,
  parameter int EV_W      = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           bus_sel,
  input logic                           bus_wr,
  input logic [NUM_FIFOS-1:0]           msg_hit,
  input logic [NUM_FIFOS-1:0][CNT_W-1:0] fifo_cnt,
  input logic [EV_W-1:0]                ev,
  input logic [NUM_USERS-1:0][EV_W-1:0] pend,
  input logic [NUM_USERS-1:0][EV_W-1:0] mask,
  input logic [NUM_USERS-1:0]           irq_out
);
  for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_f
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      fifo_cnt[m] <= CNT_W'(DEPTH));
    // R4
    drop_full_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && msg_hit[m] && fifo_cnt[m] == CNT_W'(DEPTH))
      |=> (fifo_cnt[m] == CNT_W'(DEPTH)));
    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && !bus_wr && msg_hit[m] && fifo_cnt[m] == '0)
      |=> (fifo_cnt[m] == '0));
  end

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
    for (genvar b = 0; b < EV_W; b++) begin : g_b
      // R6
      pend_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pend[u][b]) |-> $past(ev[b]));
      // R7
      event_keep_chk: assert property (@(posedge clk) disable iff (rst)
        ev[b] |=> pend[u][b]);
    end
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      ((pend[u] & mask[u]) == '0) |=> !irq_out[u]);
    // R8
    irq_fire_chk: assert property (@(posedge clk) disable iff (rst)
      ((pend[u] & mask[u]) != '0) |=> irq_out[u]);
  end
endmodule

bind mbx_top mbx_chk #(
  .NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS), .DEPTH(DEPTH),
  .CNT_W(CNT_W), .EV_W(EV_W)
) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .msg_hit(msg_hit), .fifo_cnt(fifo_cnt), .ev(ev),
  .pend(pend), .mask(mask), .irq_out(irq_out)
);

// File: tb/sim_mbx_top.sv
module sim_mbx_top;
  localparam int          CLK_PERIOD = 10;
  localparam logic [31:0] REV        = 32'h0001_0200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel0 = 1'b0, sel1 = 1'b0, wr = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic [3:0]  irq0, irq1;

  int n_run = 0, n_fail = 0;

  typedef struct {
    int          dut;
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic fire0_q = 1'b0, fire1_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_top #(.LAYOUT(1), .REV_ID(REV)) u0 (
    .clk(clk), .rst(rst), .bus_sel(sel0), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata0), .irq_out(irq0));

  mbx_top #(.LAYOUT(0), .REV_ID(REV)) u1 (
    .clk(clk), .rst(rst), .bus_sel(sel1), .bus_wr(wr), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata1), .irq_out(irq1));

  // mark the edges that sampled a read
  always @(posedge clk) begin
    fire0_q <= sel0 & ~wr;
    fire1_q <= sel1 & ~wr;
  end

  // monitor: compare registered read data against the scoreboard
  always @(negedge clk) begin
    exp_t        e;
    logic [31:0] act;
    if (fire0_q || fire1_q) begin
      n_run++;
      if (sb.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard: unexpected read, actual %h expected none",
                 fire0_q ? rdata0 : rdata1);
      end else begin
        e   = sb.pop_front();
        act = (e.dut == 1) ? rdata1 : rdata0;
        if (act !== e.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", e.tag, act, e.exp);
        end
      end
    end
  end

  task automatic wr_reg(input int dut, input logic [11:0] a, input logic [31:0] d);
    sel0 = (dut == 0); sel1 = (dut == 1); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_chk(input int dut, input logic [11:0] a, input logic [31:0] exp,
                        input string tag);
    exp_t e;
    e.dut = dut; e.exp = exp; e.tag = tag;
    sb.push_back(e);
    sel0 = (dut == 0); sel1 = (dut == 1); wr = 1'b0; addr = a;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_chk(0, 12'h0C0, 32'h0, "R1 level q0");
    rd_chk(0, 12'h080, 32'h0, "R1 full q0");
    rd_chk(0, 12'h104, 32'h0, "R1 pending u0");
    rd_chk(0, 12'h108, 32'h0, "R1 mask u0");
    rd_chk(1, 12'h100, 32'h0, "R1 pending u0 layout0");
    chk({28'b0, irq0}, 32'h0, "R1 irq layout1");
    chk({28'b0, irq1}, 32'h0, "R1 irq layout0");

    // R2 revision and unmapped
    rd_chk(0, 12'h000, REV,   "R2 revision");
    rd_chk(0, 12'h0F0, 32'h0, "R2 unmapped 0x0F0");
    rd_chk(0, 12'h100, 32'h0, "R2 unmapped 0x100 layout1");

    // R3 ordering and level
    wr_reg(0, 12'h044, 32'h1111_0001);
    wr_reg(0, 12'h044, 32'h2222_0002);
    rd_chk(0, 12'h0C4, 32'd2, "R3 level q1 after two writes");
    rd_chk(0, 12'h124, 32'h4, "R6 arrival bit q1 at user2");
    rd_chk(0, 12'h044, 32'h1111_0001, "R3 first out");
    rd_chk(0, 12'h044, 32'h2222_0002, "R3 second out");
    rd_chk(0, 12'h0C4, 32'd0, "R3 level q1 drained");

    // R5 empty read
    rd_chk(0, 12'h044, 32'h0, "R5 empty read value");
    rd_chk(0, 12'h0C4, 32'd0, "R5 level after empty read");

    // R4 full and drop
    for (int i = 0; i < 4; i++) wr_reg(0, 12'h040, 32'hA0 + i);
    rd_chk(0, 12'h080, 32'h1, "R4 full flag set");
    rd_chk(0, 12'h0C0, 32'd4, "R4 level at depth");
    wr_reg(0, 12'h040, 32'hDEAD);
    rd_chk(0, 12'h0C0, 32'd4, "R4 level after dropped write");
    rd_chk(0, 12'h040, 32'hA0, "R4 oldest after drop");
    rd_chk(0, 12'h080, 32'h0, "R4 full flag cleared");
    rd_chk(0, 12'h104, 32'h7, "R6 space and arrival bits u0");
    rd_chk(0, 12'h040, 32'hA1, "R4 order 1");
    rd_chk(0, 12'h040, 32'hA2, "R4 order 2");
    rd_chk(0, 12'h040, 32'hA3, "R4 order 3");
    rd_chk(0, 12'h040, 32'h0,  "R4 dropped word absent");

    // R7 write-one-to-clear
    wr_reg(0, 12'h104, 32'h1);
    rd_chk(0, 12'h104, 32'h6, "R7 clear bit0");
    wr_reg(0, 12'h104, 32'h0);
    rd_chk(0, 12'h104, 32'h6, "R7 zero write no effect");
    wr_reg(0, 12'h104, 32'h6);
    rd_chk(0, 12'h104, 32'h0, "R7 clear remaining");

    // R10 set/clear mask
    wr_reg(0, 12'h108, 32'h1);
    wr_reg(0, 12'h108, 32'h2);
    rd_chk(0, 12'h108, 32'h3, "R10 set ORs bits");
    rd_chk(0, 12'h10C, 32'h3, "R10 clear reg reads mask");

    // R8 interrupt timing
    wr_reg(0, 12'h040, 32'h55);
    idle();
    chk({28'b0, irq0}, 32'h1, "R8 irq on after arrival");
    wr_reg(0, 12'h10C, 32'h1);
    rd_chk(0, 12'h108, 32'h2, "R10 clear removes bit");
    chk({28'b0, irq0}, 32'h0, "R8 irq off after mask clear");
    wr_reg(0, 12'h108, 32'h1);
    idle();
    chk({28'b0, irq0}, 32'h1, "R8 irq on after re-enable");
    wr_reg(0, 12'h104, 32'h1);
    idle();
    chk({28'b0, irq0}, 32'h0, "R8 irq off after pending clear");
    rd_chk(0, 12'h114, 32'h7, "R6 user1 sees all events");

    // R9 layout 0
    wr_reg(1, 12'h104, 32'h5);
    rd_chk(1, 12'h104, 32'h5, "R9 mask write");
    wr_reg(1, 12'h104, 32'h1);
    rd_chk(1, 12'h104, 32'h1, "R9 mask overwrite");
    wr_reg(1, 12'h040, 32'h77);
    rd_chk(1, 12'h100, 32'h1, "R9 pending user0");
    rd_chk(1, 12'h108, 32'h1, "R9 pending user1");
    chk({28'b0, irq1}, 32'h1, "R9 irq layout0 user0 only");
    chk({28'b0, irq0}, 32'h0, "R2 other instance untouched");

    idle();
    idle();
    chk(sb.size(), 32'h0, "scoreboard drained");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule